// File: doc/BRIEF.md
# Program Counter with Event Save Registers

This block holds the processor's program counter and four registers that keep return addresses. The counter is 26 bits wide inside a 32-bit address, and its bit 0 is always zero. It moves in one of four ways. It can advance by 2 or 4 bytes, load a branch target, jump to an event handler vector, or reload from a save register on a return. No instruction can read or write it directly.

When an event pulse arrives, its class decides which save register receives the return address. The return address is the address of the instruction after the current one. There is one save register for maskable interrupts and software exceptions, one for non-maskable interrupts, one for traps, debug breaks and single steps, and one for table-call execution. Software can write any save register and read any of them. The debug save register reads as zero unless a debug handler is active. That window opens when a debug-group event vectors to the debug handler address. It closes when the return through the debug save register has completed.

Top module: `pc_ctx_unit`

## Requirements
- R1: While reset is asserted and after its release, the PC is 0x00000000, the debug window is closed and every save register reads 0.
- R2: PC bits 31..26 are always zero. A sequential advance (+2 when adv_wide=0, +4 when adv_wide=1) or a load that would carry beyond bit 25 drops that carry, so 0x03FFFFFC advanced by 4 gives 0x00000000.
- R3: Every PC load forces bit 0 to zero, so a branch to an odd target lands one byte lower.
- R4: When several PC sources are active in one cycle, the priority is event, then return, then branch, then advance.
- R5: An event loads the formatted evt_vector into the PC one cycle later. It also captures the formatted evt_ret_addr into a save register chosen by evt_class: 0 (software exception) and 1 (maskable) go to slot 0, 2 (non-maskable) goes to slot 1, 3 to 6 (exception trap, debug trap, debug break, single step) go to slot 2, and 7 (table call) goes to slot 3.
- R6: A software write stores sw_wr_data with bit 0 and bits 31..26 cleared. If an event captures into the same slot in the same cycle, the event's address is kept.
- R7: A return with ret_sel = 0, 1, 2 or 3 loads the PC from slot 0, 1, 2 or 3 respectively.
- R8: A read of slot 2 returns zero unless the debug window is open. The window opens after an event of class 3 to 6 whose vector is 0x00000060, and it closes after a return with ret_sel=2. An event of any other class with that vector does not open it.
- R9: A second event of the same class overwrites the earlier capture in its slot.
- R10: Reads of slots 0, 1 and 3 return the stored value whether the debug window is open or closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | 1 | Sequential advance request |
| adv_wide | input | 1 | Advance step size: 0 selects 2 bytes, 1 selects 4 bytes |
| br_en | input | 1 | Branch load request |
| br_target | input | 32 | Branch target address |
| evt_valid | input | 1 | Event pulse |
| evt_class | input | 3 | Event class code |
| evt_ret_addr | input | 32 | Address of the following instruction, to be saved |
| evt_vector | input | 32 | Handler address for the event |
| ret_en | input | 1 | Return request |
| ret_sel | input | 2 | Save slot to return from |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 2 | Save slot to write |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_sel | input | 2 | Save slot to read |
| sw_rd_data | output | 32 | Read data, gated for slot 2 |
| pc_o | output | 32 | Current program counter |
| dbg_active_o | output | 1 | Debug handler window is open |

## Verification
The assertions assume that rst_n is driven cleanly, that all inputs are known after reset, and that a return relies on the slot value present in the cycle before the PC update. The stimulus changes inputs only between clock edges and clears every request strobe after a single cycle. The addresses it uses are deliberately odd or overflowing, so that the formatting rules are exercised without ever producing an undefined slot value.

// File: rtl/pc_ctx_pkg.sv
package pc_ctx_pkg;

    typedef enum logic [2:0] {
        EV_SWEXC    = 3'd0,
        EV_MASKABLE = 3'd1,
        EV_NMI      = 3'd2,
        EV_EXCTRAP  = 3'd3,
        EV_DBGTRAP  = 3'd4,
        EV_DBGBRK   = 3'd5,
        EV_STEP     = 3'd6,
        EV_TBLCALL  = 3'd7
    } evt_class_e;

    typedef enum logic [1:0] {
        SV_INT  = 2'd0,
        SV_NMI  = 2'd1,
        SV_DBG  = 2'd2,
        SV_CALL = 2'd3
    } save_sel_e;

    localparam int NUM_SAVE = 4;

endpackage

// File: rtl/pc_evt_route.sv
module pc_evt_route
    import pc_ctx_pkg::*;
(
    input  logic [2:0] evt_class,
    output logic [1:0] save_idx,
    output logic       dbg_group
);

    always_comb begin
        save_idx  = SV_INT;
        dbg_group = 1'b0;
        case (evt_class)
            EV_SWEXC, EV_MASKABLE: save_idx = SV_INT;
            EV_NMI:                save_idx = SV_NMI;
            EV_EXCTRAP, EV_DBGTRAP, EV_DBGBRK, EV_STEP: begin
                save_idx  = SV_DBG;
                dbg_group = 1'b1;
            end
            EV_TBLCALL:            save_idx = SV_CALL;
            default:               save_idx = SV_INT;
        endcase
    end

endmodule

// File: rtl/pc_save_bank.sv
module pc_save_bank #(
    parameter int ADDR_W  = 32,
    parameter int PC_BITS = 26,
    parameter int NUM     = 4,
    localparam int IDX_W  = $clog2(NUM)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic [IDX_W-1:0]            cap_idx,
    input  logic [ADDR_W-1:0]           cap_addr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ADDR_W-1:0]           wr_data,
    output logic [NUM-1:0][ADDR_W-1:0]  slot_o
);

    localparam logic [ADDR_W-1:0] KEEP_MASK =
        ADDR_W'(((64'd1 << PC_BITS) - 64'd1) & ~64'd1);

    typedef struct packed {
        logic [NUM-1:0][ADDR_W-1:0] slot;
    } bank_t;

    bank_t st_d, st_q;

    logic [NUM-1:0] cap_hit;
    logic [NUM-1:0] wr_hit;

    for (genvar g = 0; g < NUM; g++) begin : g_hit
        assign cap_hit[g] = cap_en && (cap_idx == IDX_W'(g));
        assign wr_hit[g]  = wr_en  && (wr_idx  == IDX_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (cap_hit[i]) begin
                st_d.slot[i] = cap_addr & KEEP_MASK;
            end else if (wr_hit[i]) begin
                st_d.slot[i] = wr_data & KEEP_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;

endmodule

// File: rtl/pc_ctx_unit.sv
module pc_ctx_unit
    import pc_ctx_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              PC_BITS    = 26,
    parameter logic [31:0]     DBG_VECTOR = 32'h0000_0060
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic              adv_wide,
    input  logic              br_en,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              evt_valid,
    input  logic [2:0]        evt_class,
    input  logic [ADDR_W-1:0] evt_ret_addr,
    input  logic [ADDR_W-1:0] evt_vector,
    input  logic              ret_en,
    input  logic [1:0]        ret_sel,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_sel,
    input  logic [ADDR_W-1:0] sw_wr_data,
    input  logic [1:0]        sw_rd_sel,
    output logic [ADDR_W-1:0] sw_rd_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic              dbg_active_o
);

    localparam logic [ADDR_W-1:0] KEEP_MASK =
        ADDR_W'(((64'd1 << PC_BITS) - 64'd1) & ~64'd1);
    localparam logic [ADDR_W-1:0] DBG_VEC_F = ADDR_W'(DBG_VECTOR) & KEEP_MASK;
    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(4);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              dbg_active;
    } core_t;

    core_t cur_q, nxt_d;

    logic [1:0]                       route_idx;
    logic                             route_dbg;
    logic [NUM_SAVE-1:0][ADDR_W-1:0]  bank_q;
    logic [ADDR_W-1:0]                seq_sum;
    logic [ADDR_W-1:0]                vec_f;

    pc_evt_route u_route (
        .evt_class (evt_class),
        .save_idx  (route_idx),
        .dbg_group (route_dbg)
    );

    pc_save_bank #(
        .ADDR_W  (ADDR_W),
        .PC_BITS (PC_BITS),
        .NUM     (NUM_SAVE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (evt_valid),
        .cap_idx  (route_idx),
        .cap_addr (evt_ret_addr),
        .wr_en    (sw_wr_en),
        .wr_idx   (sw_wr_sel),
        .wr_data  (sw_wr_data),
        .slot_o   (bank_q)
    );

    assign seq_sum = cur_q.pc + (adv_wide ? STEP_WIDE : STEP_NARROW);
    assign vec_f   = evt_vector & KEEP_MASK;

    always_comb begin
        nxt_d = cur_q;
        if (evt_valid) begin
            nxt_d.pc = vec_f;
            if (route_dbg && (vec_f == DBG_VEC_F)) begin
                nxt_d.dbg_active = 1'b1;
            end
        end else if (ret_en) begin
            nxt_d.pc = bank_q[ret_sel] & KEEP_MASK;
            if (ret_sel == SV_DBG) begin
                nxt_d.dbg_active = 1'b0;
            end
        end else if (br_en) begin
            nxt_d.pc = br_target & KEEP_MASK;
        end else if (adv_en) begin
            nxt_d.pc = seq_sum & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        sw_rd_data = bank_q[sw_rd_sel];
        if ((sw_rd_sel == SV_DBG) && !cur_q.dbg_active) begin
            sw_rd_data = '0;
        end
    end

    assign pc_o         = cur_q.pc;
    assign dbg_active_o = cur_q.dbg_active;

endmodule

// File: rtl/pc_ctx_chk.sv
module pc_ctx_chk #(
    parameter int          ADDR_W     = 32,
    parameter int          PC_BITS    = 26,
    parameter logic [31:0] DBG_VECTOR = 32'h0000_0060
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    evt_valid,
    input logic [2:0]              evt_class,
    input logic [ADDR_W-1:0]       evt_vector,
    input logic                    ret_en,
    input logic [1:0]              ret_sel,
    input logic [1:0]              sw_rd_sel,
    input logic [ADDR_W-1:0]       sw_rd_data,
    input logic [ADDR_W-1:0]       pc_o,
    input logic                    dbg_active_o,
    input logic [3:0][ADDR_W-1:0]  bank_q
);

    localparam logic [ADDR_W-1:0] MASK =
        ADDR_W'(((64'd1 << PC_BITS) - 64'd1) & ~64'd1);
    localparam logic [ADDR_W-1:0] DVEC = ADDR_W'(DBG_VECTOR) & MASK;

    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && !dbg_active_o));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o & ~MASK & ~ADDR_W'(1)) == '0);

    a_r3_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == 1'b0);

    a_r5_evt_vector: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> pc_o == ($past(evt_vector) & MASK));

    a_r7_return_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !evt_valid) |=> pc_o == ($past(bank_q[ret_sel]) & MASK));

    a_r8_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_class >= 3'd3 && evt_class <= 3'd6
         && (evt_vector & MASK) == DVEC) |=> dbg_active_o);

    a_r8_window_close: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !evt_valid && ret_sel == 2'd2) |=> !dbg_active_o);

    a_r8_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd_sel == 2'd2 && !dbg_active_o) |-> sw_rd_data == '0);

endmodule

bind pc_ctx_unit pc_ctx_chk #(
    .ADDR_W     (ADDR_W),
    .PC_BITS    (PC_BITS),
    .DBG_VECTOR (DBG_VECTOR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_valid    (evt_valid),
    .evt_class    (evt_class),
    .evt_vector   (evt_vector),
    .ret_en       (ret_en),
    .ret_sel      (ret_sel),
    .sw_rd_sel    (sw_rd_sel),
    .sw_rd_data   (sw_rd_data),
    .pc_o         (pc_o),
    .dbg_active_o (dbg_active_o),
    .bank_q       (bank_q)
);

// File: tb/sim_pc_ctx_unit.sv
module sim_pc_ctx_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv_en, adv_wide, br_en, evt_valid, ret_en, sw_wr_en;
    logic [31:0] br_target, evt_ret_addr, evt_vector, sw_wr_data;
    logic [2:0]  evt_class;
    logic [1:0]  ret_sel, sw_wr_sel, sw_rd_sel;
    logic [31:0] sw_rd_data, pc_o;
    logic        dbg_active_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_ctx_unit u0 (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .adv_wide(adv_wide),
        .br_en(br_en), .br_target(br_target), .evt_valid(evt_valid),
        .evt_class(evt_class), .evt_ret_addr(evt_ret_addr), .evt_vector(evt_vector),
        .ret_en(ret_en), .ret_sel(ret_sel), .sw_wr_en(sw_wr_en),
        .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data), .sw_rd_sel(sw_rd_sel),
        .sw_rd_data(sw_rd_data), .pc_o(pc_o), .dbg_active_o(dbg_active_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        adv_en = 0; adv_wide = 0; br_en = 0; br_target = '0;
        evt_valid = 0; evt_class = '0; evt_ret_addr = '0; evt_vector = '0;
        ret_en = 0; ret_sel = '0; sw_wr_en = 0; sw_wr_sel = '0; sw_wr_data = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        sw_rd_sel = sel;
        #1;
        val = sw_rd_data;
    endtask

    task automatic event_pulse(input logic [2:0] cls, input logic [31:0] ra, input logic [31:0] vec);
        evt_valid = 1; evt_class = cls; evt_ret_addr = ra; evt_vector = vec;
        tick();
    endtask

    task automatic swr(input logic [1:0] sel, input logic [31:0] d);
        sw_wr_en = 1; sw_wr_sel = sel; sw_wr_data = d;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pc in reset", pc_o, 32'h0);
        rst_n = 1;
        tick();
        chk("R1 pc after reset", pc_o, 32'h0);
        chk("R1 window closed", {31'b0, dbg_active_o}, 32'h0);
        rd(2'd0, v); chk("R1 slot0", v, 32'h0);
        rd(2'd1, v); chk("R1 slot1", v, 32'h0);
        rd(2'd3, v); chk("R1 slot3", v, 32'h0);
    endtask

    task automatic t_advance();
        adv_en = 1; tick();
        chk("R2 advance by 2", pc_o, 32'h2);
        adv_en = 1; adv_wide = 1; tick();
        chk("R2 advance by 4", pc_o, 32'h6);
        br_en = 1; br_target = 32'h03FF_FFFC; tick();
        adv_en = 1; adv_wide = 1; tick();
        chk("R2 carry dropped", pc_o, 32'h0);
        br_en = 1; br_target = 32'hFFFF_FFFF; tick();
        chk("R2 upper bits cleared", pc_o, 32'h03FF_FFFE);
    endtask

    task automatic t_branch();
        br_en = 1; br_target = 32'h0000_1235; tick();
        chk("R3 odd target", pc_o, 32'h0000_1234);
    endtask

    task automatic t_routing();
        logic [31:0] v;
        for (int c = 0; c < 8; c++) begin
            event_pulse(3'(c), 32'h1001 + 32'(c) * 32'h10, 32'h0000_0201);
            chk("R5 vector load", pc_o, 32'h0000_0200);
        end
        rd(2'd0, v); chk("R5 slot0 from class1", v, 32'h1010);
        rd(2'd1, v); chk("R5 slot1 from class2", v, 32'h1020);
        rd(2'd3, v); chk("R5 slot3 from class7", v, 32'h1070);
        rd(2'd2, v); chk("R8 slot2 closed read", v, 32'h0);
        ret_en = 1; ret_sel = 2'd2; tick();
        chk("R5 slot2 from class6 via return", pc_o, 32'h1060);
    endtask

    task automatic t_nested();
        logic [31:0] v;
        event_pulse(3'd1, 32'h0000_3000, 32'h100);
        event_pulse(3'd1, 32'h0000_3400, 32'h100);
        rd(2'd0, v); chk("R9 nested overwrite", v, 32'h3400);
    endtask

    task automatic t_swwrite();
        logic [31:0] v;
        swr(2'd3, 32'hFC00_1237);
        rd(2'd3, v); chk("R6 write formatted", v, 32'h0000_1236);
        sw_wr_en = 1; sw_wr_sel = 2'd1; sw_wr_data = 32'h4444;
        evt_valid = 1; evt_class = 3'd2; evt_ret_addr = 32'h8888; evt_vector = 32'h40;
        tick();
        rd(2'd1, v); chk("R6 event beats write", v, 32'h8888);
    endtask

    task automatic t_return();
        swr(2'd0, 32'h0000_2223);
        ret_en = 1; ret_sel = 2'd0; tick();
        chk("R7 return slot0", pc_o, 32'h2222);
        ret_en = 1; ret_sel = 2'd3; tick();
        chk("R7 return slot3", pc_o, 32'h1236);
        ret_en = 1; ret_sel = 2'd1; tick();
        chk("R7 return slot1", pc_o, 32'h8888);
    endtask

    task automatic t_priority();
        br_en = 1; br_target = 32'h500; adv_en = 1; tick();
        chk("R4 branch over advance", pc_o, 32'h500);
        ret_en = 1; ret_sel = 2'd0; br_en = 1; br_target = 32'h600; tick();
        chk("R4 return over branch", pc_o, 32'h2222);
        evt_valid = 1; evt_class = 3'd7; evt_ret_addr = 32'h700; evt_vector = 32'h80;
        ret_en = 1; ret_sel = 2'd0; tick();
        chk("R4 event over return", pc_o, 32'h80);
    endtask

    task automatic t_debug();
        logic [31:0] v;
        swr(2'd2, 32'h5551);
        rd(2'd2, v); chk("R8 closed read zero", v, 32'h0);
        event_pulse(3'd2, 32'h900, 32'h60);
        chk("R8 NMI class keeps closed", {31'b0, dbg_active_o}, 32'h0);
        event_pulse(3'd4, 32'h7001, 32'h60);
        chk("R8 window open", {31'b0, dbg_active_o}, 32'h1);
        chk("R8 debug vector", pc_o, 32'h60);
        rd(2'd2, v); chk("R8 open read", v, 32'h7000);
        rd(2'd0, v); chk("R10 slot0 with window open", v, 32'h2222);
        ret_en = 1; ret_sel = 2'd2; tick();
        chk("R8 return pc", pc_o, 32'h7000);
        chk("R8 window closed", {31'b0, dbg_active_o}, 32'h0);
        rd(2'd2, v); chk("R8 closed again", v, 32'h0);
        rd(2'd1, v); chk("R10 slot1 with window closed", v, 32'h900);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        sw_rd_sel = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_advance();
        t_branch();
        t_routing();
        t_nested();
        t_swwrite();
        t_return();
        t_priority();
        t_debug();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule